// File: doc/BRIEF.md
# Serial IRQ host controller

This block is the host end of a one-wire interrupt bus that runs on the bus clock. The wire is open-drain and pulled high, and the host and every peripheral share it. The host opens each polling cycle with a Start frame and then times 21 data frames. In each data frame one interrupt source reports its level by pulling the wire low or leaving it high. The host closes the cycle with a Stop frame. The length of the Stop frame tells the peripherals whether the next cycle is host-polled (continuous) or peripheral-triggered (quiet). The host latches each sampled level into a parallel status vector.

Every driver on the wire keeps a three-step discipline: it drives low, then drives high for one clock, then releases. In continuous mode the host starts a new cycle as soon as the previous one ends. In quiet mode the wire stays released until a peripheral pulls it low. The host then takes over and finishes the Start frame, counting the peripheral's clock as the first clock of the frame. A 2-bit select sets the Start width. The wire is modelled as a drive-enable and drive-value pair plus the resolved level that the block reads back.

Top module: `sirq_host`

## Requirements
- R1: While reset is asserted, and after it, the block leaves the wire released (`drv_en` = 0) and every bit of `irq_status` reads 0.
- R2: A host-launched Start frame drives the wire low for 4 clocks when `sf_width_sel` = 00, 6 clocks when it is 01, and 8 clocks when it is 10 or 11.
- R3: Every Start frame is followed by exactly one clock driven high (`drv_en`=1, `drv_val`=1) and then one clock released.
- R4: The data frames follow the Start turn-around and are 21 in number, each 3 clocks long. The host keeps the wire released throughout them and samples it in the first clock of each frame. Frame i maps to `irq_status[i]`, and the bit becomes 1 when the sampled level was low and 0 when it was high. The frame order and bit order are: 0 IRQ0, 1 IRQ1, 2 SMI#, 3 to 15 IRQ3 to IRQ15, 16 IOCHK#, 17 to 20 INTA# to INTD#.
- R5: Each status bit keeps its value until its own frame is sampled in a later cycle. Bits whose frames have not yet been reached in the current cycle still show the previous cycle's values.
- R6: The Stop frame drives low for 2 clocks when `next_quiet` = 1 and for 3 clocks when `next_quiet` = 0. The value taken is the one present on the clock that ends the last data frame. The Stop frame is followed by one clock driven high and one clock released.
- R7: In continuous mode, the next Start frame begins on the clock right after the Stop turn-around, and the first Start frame after enable begins on the clock after `en` is first seen high.
- R8: In quiet mode the host keeps the wire released until it samples the wire low. It counts that clock as the first clock of the Start frame and drives low for the configured width minus one clock.
- R9: When `en` is low the block is idle on the next clock: the wire is released, peripheral activity is ignored, and the status is held. Re-enabling always starts in continuous mode, even when the last Stop frame selected quiet mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Protocol enable |
| sf_width_sel | input | 2 | Start frame width select (00:4, 01:6, 1x:8 clocks) |
| next_quiet | input | 1 | Mode requested for the next cycle (1 = quiet) |
| line_in | input | 1 | Resolved level of the shared wire |
| drv_en | output | 1 | Host is driving the wire |
| drv_val | output | 1 | Level driven when `drv_en` is 1 |
| irq_status | output | 21 | Latched interrupt levels, 1 = asserted |

## Verification
The bench plays the peripheral side and sends several status patterns: all released, all asserted, two alternating patterns, sparse end bits and an irregular word. Together they separate a correct frame-to-bit mapping from a shifted, reversed or inverted one. Each width select is tried in continuous mode, and two of them also in quiet mode. This shows the minus-one-clock quiet launch apart from a full-width one, and it checks the Stop length against the requested mode. Partial-cycle snapshots of the status show whether unsampled bits hold their old values. A disable while waiting in quiet mode, with a peripheral pulse during the disable, shows that the pulse is ignored and that the block resumes in continuous mode.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SF_LOW,
    ST_SF_REC,
    ST_SF_TA,
    ST_DATA,
    ST_SP_LOW,
    ST_SP_REC,
    ST_SP_TA,
    ST_QWAIT
  } sirq_state_t;

  // Start frame length in clocks for a given width select
  function automatic int unsigned sf_len(input logic [1:0] sel,
                                         input int unsigned w0,
                                         input int unsigned w1,
                                         input int unsigned w2);
    case (sel)
      2'b00:   sf_len = w0;
      2'b01:   sf_len = w1;
      default: sf_len = w2;
    endcase
  endfunction

endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 21,
  parameter int unsigned SF_W0      = 4,
  parameter int unsigned SF_W1      = 6,
  parameter int unsigned SF_W2      = 8,
  parameter int unsigned STOP_QUIET = 2,
  parameter int unsigned STOP_CONT  = 3,
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES),
  localparam int unsigned MAX_SF    = (SF_W0 > SF_W1) ? ((SF_W0 > SF_W2) ? SF_W0 : SF_W2)
                                                      : ((SF_W1 > SF_W2) ? SF_W1 : SF_W2),
  localparam int unsigned MAX_LEN   = (MAX_SF > STOP_CONT) ? MAX_SF : STOP_CONT,
  localparam int unsigned CNT_W     = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [1:0]         width_sel,
  input  logic               next_quiet,
  input  logic               line_in,
  output sirq_state_t        state_o,
  output logic               sample_stb,
  output logic [FRAME_W-1:0] frame_idx
);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);

  sirq_state_t        state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [1:0]         phase_q, phase_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               quiet_q, quiet_d;
  logic [CNT_W-1:0]   sf_full, sf_short;

  assign sf_full  = CNT_W'(sf_len(width_sel, SF_W0, SF_W1, SF_W2) - 1);
  assign sf_short = CNT_W'(sf_len(width_sel, SF_W0, SF_W1, SF_W2) - 2);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    frame_d = frame_q;
    quiet_d = quiet_q;
    if (!en) begin
      state_d = ST_IDLE;
      quiet_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_SF_LOW;
          cnt_d   = sf_full;
          quiet_d = 1'b0;
        end
        ST_SF_LOW: begin
          if (cnt_q == '0) state_d = ST_SF_REC;
          else             cnt_d   = cnt_q - CNT_W'(1);
        end
        ST_SF_REC: state_d = ST_SF_TA;
        ST_SF_TA: begin
          state_d = ST_DATA;
          phase_d = 2'd0;
          frame_d = '0;
        end
        ST_DATA: begin
          if (phase_q == 2'd2) begin
            phase_d = 2'd0;
            if (frame_q == LAST_FRAME) begin
              state_d = ST_SP_LOW;
              quiet_d = next_quiet;
              cnt_d   = next_quiet ? CNT_W'(STOP_QUIET - 1) : CNT_W'(STOP_CONT - 1);
            end else begin
              frame_d = frame_q + FRAME_W'(1);
            end
          end else begin
            phase_d = phase_q + 2'd1;
          end
        end
        ST_SP_LOW: begin
          if (cnt_q == '0) state_d = ST_SP_REC;
          else             cnt_d   = cnt_q - CNT_W'(1);
        end
        ST_SP_REC: state_d = ST_SP_TA;
        ST_SP_TA: begin
          if (quiet_q) begin
            state_d = ST_QWAIT;
          end else begin
            state_d = ST_SF_LOW;
            cnt_d   = sf_full;
          end
        end
        ST_QWAIT: begin
          if (!line_in) begin
            state_d = ST_SF_LOW;
            cnt_d   = sf_short;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= 2'd0;
      frame_q <= '0;
      quiet_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      frame_q <= frame_d;
      quiet_q <= quiet_d;
    end
  end

  assign state_o    = state_q;
  assign sample_stb = (state_q == ST_DATA) && (phase_q == 2'd0);
  assign frame_idx  = frame_q;
endmodule

// File: rtl/sirq_drive.sv
module sirq_drive
  import sirq_pkg::*;
(
  input  sirq_state_t state,
  output logic        drv_en,
  output logic        drv_val
);
  always_comb begin
    drv_en  = 1'b0;
    drv_val = 1'b1;
    unique case (state)
      ST_SF_LOW, ST_SP_LOW: begin
        drv_en  = 1'b1;
        drv_val = 1'b0;
      end
      ST_SF_REC, ST_SP_REC: begin
        drv_en  = 1'b1;
        drv_val = 1'b1;
      end
      default: begin
        drv_en  = 1'b0;
        drv_val = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sirq_status.sv
module sirq_status #(
  parameter int unsigned NUM_FRAMES = 21,
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_stb,
  input  logic [FRAME_W-1:0]    frame_idx,
  input  logic                  line_in,
  output logic [NUM_FRAMES-1:0] status
);
  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_bit
    logic hit;
    assign hit = sample_stb && (frame_idx == FRAME_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   status[i] <= 1'b0;
      else if (hit) status[i] <= ~line_in;
    end
  end
endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int unsigned NUM_FRAMES = 21,
  parameter int unsigned SF_W0      = 4,
  parameter int unsigned SF_W1      = 6,
  parameter int unsigned SF_W2      = 8,
  parameter int unsigned STOP_QUIET = 2,
  parameter int unsigned STOP_CONT  = 3,
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [1:0]            sf_width_sel,
  input  logic                  next_quiet,
  input  logic                  line_in,
  output logic                  drv_en,
  output logic                  drv_val,
  output logic [NUM_FRAMES-1:0] irq_status
);
  logic                  rst_n_i;
  sirq_pkg::sirq_state_t st;
  logic                  sample_stb;
  logic [FRAME_W-1:0]    frame_idx;

  sirq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  sirq_seq #(
    .NUM_FRAMES (NUM_FRAMES),
    .SF_W0      (SF_W0),
    .SF_W1      (SF_W1),
    .SF_W2      (SF_W2),
    .STOP_QUIET (STOP_QUIET),
    .STOP_CONT  (STOP_CONT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .en         (en),
    .width_sel  (sf_width_sel),
    .next_quiet (next_quiet),
    .line_in    (line_in),
    .state_o    (st),
    .sample_stb (sample_stb),
    .frame_idx  (frame_idx)
  );

  sirq_drive u_drv (
    .state   (st),
    .drv_en  (drv_en),
    .drv_val (drv_val)
  );

  sirq_status #(
    .NUM_FRAMES (NUM_FRAMES)
  ) u_stat (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .sample_stb (sample_stb),
    .frame_idx  (frame_idx),
    .line_in    (line_in),
    .status     (irq_status)
  );
endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
  parameter int unsigned NUM_FRAMES = 21,
  parameter int unsigned MAX_LOW    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic                  line_in,
  input logic                  drv_en,
  input logic                  drv_val,
  input logic [NUM_FRAMES-1:0] irq_status,
  input sirq_pkg::sirq_state_t st
);
  logic [7:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_run <= 8'd0;
    else if (drv_en && !drv_val) low_run <= low_run + 8'd1;
    else                       low_run <= 8'd0;
  end

  // R9
  en_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !drv_en);

  // R3
  high_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && drv_val) |=> !drv_en);

  // R6
  high_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && drv_val) |-> $past(drv_en && !drv_val));

  // R2
  low_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 8'(MAX_LOW));

  // R5
  one_bit_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_status ^ $past(irq_status)) <= 1);

  // R4
  update_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status != $past(irq_status)) |-> !$past(drv_en));

  // R8
  quiet_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == sirq_pkg::ST_QWAIT && !line_in) |=> (drv_en && !drv_val));
endmodule

bind sirq_host sirq_host_chk #(.NUM_FRAMES(NUM_FRAMES), .MAX_LOW(SF_W2)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .line_in    (line_in),
  .drv_en     (drv_en),
  .drv_val    (drv_val),
  .irq_status (irq_status),
  .st         (st)
);

// File: tb/sirq_host_tb_top.sv
module sirq_host_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, en, next_quiet, periph_low;
  logic [1:0]  sf_width_sel;
  logic        drv_en, drv_val;
  logic [20:0] irq_status;
  wire         line_in = (drv_en ? drv_val : 1'b1) & ~periph_low;

  int          n_chk = 0;
  int          n_err = 0;
  logic [20:0] exp_q[$];
  logic [20:0] last_pat = '0;
  event        cyc_end;

  always #10 clk = ~clk;

  sirq_host dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .sf_width_sel (sf_width_sel),
    .next_quiet   (next_quiet),
    .line_in      (line_in),
    .drv_en       (drv_en),
    .drv_val      (drv_val),
    .irq_status   (irq_status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_sim();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Monitor: compares the latched status with the queued expectation at each Stop
  initial begin
    forever begin
      @(cyc_end);
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected cycle end", 0, 1);
      end else begin
        logic [20:0] e;
        e = exp_q.pop_front();
        check(irq_status == e, "R4", "status after data frames", int'(irq_status), int'(e));
        last_pat = e;
      end
    end
  end

  // Driver: plays the peripherals through one full cycle
  task automatic run_cycle(input logic [20:0] pat, input logic [1:0] sel,
                           input logic nq, input bit qstart, input int idle_n);
    int  expw, n;
    bit  rel_ok;
    sf_width_sel = sel;
    next_quiet   = nq;
    expw = (sel == 2'd0) ? 4 : (sel == 2'd1) ? 6 : 8;
    exp_q.push_back(pat);
    if (qstart) begin
      rel_ok = 1'b1;
      for (int k = 0; k < idle_n; k++) begin
        @(negedge clk);
        if (drv_en) rel_ok = 1'b0;
      end
      check(rel_ok, "R8", "released while waiting in quiet mode", int'(rel_ok), 1);
      periph_low = 1'b1;
      @(negedge clk);
      periph_low = 1'b0;
      expw = expw - 1;
    end else begin
      @(negedge clk);
      // R7 (and R9 after re-enable): low starts on the very next clock
      check(drv_en && !drv_val, "R7", "start frame begins immediately",
            int'({drv_en, drv_val}), 2);
    end
    n = 0;
    while (drv_en && !drv_val && n < 20) begin
      n++;
      @(negedge clk);
    end
    check(n == expw, qstart ? "R8" : "R2", "start frame low clocks", n, expw);
    check(drv_en && drv_val, "R3", "start recovery driven high", int'({drv_en, drv_val}), 3);
    @(negedge clk);
    check(!drv_en, "R3", "start turn-around released", int'(drv_en), 0);
    rel_ok = 1'b1;
    for (int t = 0; t < 63; t++) begin
      @(negedge clk);
      periph_low = (t % 3 == 0) ? pat[t / 3] : 1'b0;
      if (drv_en) rel_ok = 1'b0;
      if (t == 0)
        check(irq_status == last_pat, "R5", "status held at cycle begin",
              int'(irq_status), int'(last_pat));
      if (t == 30)
        check(irq_status[20:10] == last_pat[20:10], "R5", "unsampled bits held mid-cycle",
              int'(irq_status[20:10]), int'(last_pat[20:10]));
    end
    check(rel_ok, "R4", "host released during data frames", int'(rel_ok), 1);
    @(negedge clk);
    periph_low = 1'b0;
    -> cyc_end;
    n = 0;
    while (drv_en && !drv_val && n < 20) begin
      n++;
      @(negedge clk);
    end
    check(n == (nq ? 2 : 3), "R6", "stop frame low clocks", n, nq ? 2 : 3);
    check(drv_en && drv_val, "R6", "stop recovery driven high", int'({drv_en, drv_val}), 3);
    @(negedge clk);
    check(!drv_en, "R6", "stop turn-around released", int'(drv_en), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_sim();
  end

  initial begin
    bit ok;
    rst_n = 1'b0; en = 1'b0; periph_low = 1'b0; next_quiet = 1'b0; sf_width_sel = 2'd0;
    repeat (3) @(negedge clk);
    check(!drv_en && irq_status == '0, "R1", "reset state", int'(irq_status), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!drv_en && irq_status == '0, "R1", "idle after reset release", int'(drv_en), 0);
    en = 1'b1;

    run_cycle(21'h000000, 2'd0, 1'b0, 1'b0, 0);
    run_cycle(21'h1FFFFF, 2'd1, 1'b0, 1'b0, 0);
    run_cycle(21'h155555, 2'd2, 1'b0, 1'b0, 0);
    run_cycle(21'h0AAAAA, 2'd3, 1'b1, 1'b0, 0);
    run_cycle(21'h100001, 2'd0, 1'b1, 1'b1, 5);
    run_cycle(21'h012345, 2'd2, 1'b0, 1'b1, 2);
    run_cycle(21'h0F0F0F, 2'd0, 1'b1, 1'b0, 0);

    // R9: disable while waiting in quiet mode; a peripheral pulse is ignored
    @(negedge clk);
    en = 1'b0;
    ok = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (drv_en) ok = 1'b0;
    end
    periph_low = 1'b1;
    @(negedge clk);
    periph_low = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (drv_en) ok = 1'b0;
    end
    check(ok, "R9", "released while disabled", int'(ok), 1);
    check(irq_status == last_pat, "R9", "status held while disabled",
          int'(irq_status), int'(last_pat));

    // R9: re-enable starts in continuous mode despite quiet request before
    en = 1'b1;
    run_cycle(21'h1E0F03, 2'd1, 1'b0, 1'b0, 0);

    repeat (2) @(negedge clk);
    finish_sim();
  end
endmodule